// File: doc/BRIEF.md
# Serpentine tiled framebuffer address generator

This block walks a rectangular window of a 32-bit-per-pixel framebuffer in raster order and produces, for each pixel, its coordinates and its byte offset in a tiled memory layout. The layout has four levels:

- A 4x4 pixel micro-tile occupies 64 bytes.
- Sixteen micro-tiles form a 16x16 pixel sub-tile of 1 KB.
- Four sub-tiles form a 32x32 pixel tile of 4 KB.
- Tiles are laid out in rows that change direction from one tile row to the next.

The order of the four sub-tiles inside a tile also depends on whether the tile row is even or odd.

A one-cycle start pulse latches the window width and height. The block then presents one pixel per clock on a valid/ready output stream. After the final pixel is accepted, it raises a one-cycle done pulse. A downstream fetch unit uses the offsets to read a tiled surface as if it were a linear raster scan.

Top module: `ttile_addr_gen`

## Requirements
- R1: After reset, out_valid_o and done_o are low.
- R2: A start pulse while idle latches width_i and height_i, both at least 1. In the following cycle, out_valid_o is high with out_x_o = 0 and out_y_o = 0.
- R3: Each accepted pixel (valid and ready high at a clock edge) advances x by one. After x = width-1, x returns to 0 and y increments.
- R4: While out_valid_o is high and out_ready_i is low, out_valid_o, out_x_o, out_y_o and out_offset_o hold their values.
- R5: In the cycle after the pixel (width-1, height-1) is accepted, done_o is high for exactly one cycle and out_valid_o is low. At all other times done_o is low.
- R6: A start pulse during a walk has no effect: the walk continues with the originally latched size.
- R7: Offset bits [5:0] equal ((y mod 4)*4 + (x mod 4))*4.
- R8: Offset bits [9:6] equal ((y mod 16) div 4)*4 + (x mod 16) div 4. Micro-tile rows are ordered by increasing y.
- R9: Offset bits [11:10] give the sub-tile slot. Left means x mod 32 < 16. Top means y mod 32 < 16. On even tile rows (y div 32 even), the slots are: left-bottom 0, left-top 1, right-top 2, right-bottom 3. On odd tile rows, the slots are: right-top 0, right-bottom 1, left-bottom 2, left-top 3.
- R10: Offset bits above bit 11 equal ty*T + c. Here T = (width+31) div 32, ty = y div 32, and c = x div 32 on even tile rows or T-1-(x div 32) on odd tile rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse, used only while idle |
| width_i | input | COORD_W | Window width in pixels |
| height_i | input | COORD_W | Window height in pixels |
| out_ready_i | input | 1 | Downstream ready |
| out_valid_o | output | 1 | Pixel output valid |
| out_x_o | output | COORD_W | Pixel x coordinate |
| out_y_o | output | COORD_W | Pixel y coordinate |
| out_offset_o | output | 2*COORD_W+2 | Tiled byte offset of the pixel |
| done_o | output | 1 | One-cycle pulse after the final pixel is accepted |

## Verification
A wrong coordinate counter shows up on the very next accepted pixel, as a coordinate or offset that differs from the reference model. A wrong sub-tile slot or tile direction first shows up at the first pixel that crosses x = 16 or y = 32, so the windows are sized to cross both boundaries and to leave partial tiles at the right edge. A wrong end-of-walk state shows up within one cycle of the final handshake, as a missing, late or stretched done pulse or as a valid that stays high.

// File: rtl/ttile_pkg.sv
package ttile_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/ttile_walker.sv
module ttile_walker
  import ttile_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [COORD_W-1:0] width_i,
  input  logic [COORD_W-1:0] height_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [COORD_W-1:0] x_o,
  output logic [COORD_W-1:0] y_o,
  output logic               done_o,
  output logic               load_o,
  output logic [COORD_W-1:0] nx_o,
  output logic [COORD_W-1:0] ny_o,
  output logic [COORD_W-1:0] nw_o
);
  walk_state_e       state_q, state_d;
  logic [COORD_W-1:0] x_q, x_d, y_q, y_d, w_q, w_d, h_q, h_d;
  logic               done_q, done_d;
  logic               take, fire, row_end, last;

  always_comb begin
    take    = (state_q == WALK_IDLE) && start_i;
    fire    = (state_q == WALK_RUN) && ready_i;
    row_end = (x_q == w_q - 1'b1);
    last    = row_end && (y_q == h_q - 1'b1);
    state_d = state_q;
    x_d     = x_q;
    y_d     = y_q;
    w_d     = w_q;
    h_d     = h_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    if (take) begin
      state_d = WALK_RUN;
      x_d     = '0;
      y_d     = '0;
      w_d     = width_i;
      h_d     = height_i;
      load_o  = 1'b1;
    end else if (fire) begin
      if (last) begin
        state_d = WALK_IDLE;
        done_d  = 1'b1;
      end else begin
        load_o = 1'b1;
        if (row_end) begin
          x_d = '0;
          y_d = y_q + 1'b1;
        end else begin
          x_d = x_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      done_q  <= 1'b0;
      x_q     <= '0;
      y_q     <= '0;
      w_q     <= '0;
      h_q     <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (load_o) begin
        x_q <= x_d;
        y_q <= y_d;
      end
      if (take) begin
        w_q <= w_d;
        h_q <= h_d;
      end
    end
  end

  assign valid_o = (state_q == WALK_RUN);
  assign x_o     = x_q;
  assign y_o     = y_q;
  assign done_o  = done_q;
  assign nx_o    = x_d;
  assign ny_o    = y_d;
  assign nw_o    = take ? width_i : w_q;

  // R6: a start pulse during a walk leaves the latched size untouched
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && start_i) |=> ($stable(w_q) && $stable(h_q)));

  // R3: the presented coordinates stay inside the latched window
  p_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (x_q < w_q && y_q < h_q));
endmodule

// File: rtl/ttile_mapper.sv
module ttile_mapper #(
  parameter int COORD_W = 12
) (
  input  logic [COORD_W-1:0]   x_i,
  input  logic [COORD_W-1:0]   y_i,
  input  logic [COORD_W-1:0]   w_i,
  output logic [2*COORD_W+1:0] off_o
);
  localparam int OFF_W  = 2 * COORD_W + 2;
  localparam int TILE_W = OFF_W - 12;

  logic [COORD_W:0]   w_ext;
  logic [OFF_W-1:0]   tpr_e, tx_e, ty_e, col_e, tile_e;
  logic               odd_row, right, bottom;
  logic [1:0]         slot;
  logic [3:0]         micro, pix;

  always_comb begin
    w_ext   = {1'b0, w_i} + (COORD_W+1)'(31);
    tpr_e   = OFF_W'(w_ext >> 5);
    tx_e    = OFF_W'(x_i >> 5);
    ty_e    = OFF_W'(y_i >> 5);
    odd_row = y_i[5];
    right   = x_i[4];
    bottom  = y_i[4];
    col_e   = odd_row ? (tpr_e - 1'b1 - tx_e) : tx_e;
    tile_e  = ty_e * tpr_e + col_e;
    unique case ({odd_row, right, bottom})
      3'b000:  slot = 2'd1;
      3'b001:  slot = 2'd0;
      3'b010:  slot = 2'd2;
      3'b011:  slot = 2'd3;
      3'b100:  slot = 2'd3;
      3'b101:  slot = 2'd2;
      3'b110:  slot = 2'd0;
      default: slot = 2'd1;
    endcase
    micro = {y_i[3:2], x_i[3:2]};
    pix   = {y_i[1:0], x_i[1:0]};
    off_o = {tile_e[TILE_W-1:0], slot, micro, pix, 2'b00};
  end
endmodule

// File: rtl/ttile_addr_gen.sv
module ttile_addr_gen #(
  parameter int COORD_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [COORD_W-1:0]   width_i,
  input  logic [COORD_W-1:0]   height_i,
  input  logic                 out_ready_i,
  output logic                 out_valid_o,
  output logic [COORD_W-1:0]   out_x_o,
  output logic [COORD_W-1:0]   out_y_o,
  output logic [2*COORD_W+1:0] out_offset_o,
  output logic                 done_o
);
  localparam int OFF_W = 2 * COORD_W + 2;

  logic               load;
  logic [COORD_W-1:0] nx, ny, nw;
  logic [OFF_W-1:0]   off_d, off_q;

  ttile_walker #(.COORD_W(COORD_W)) walker_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .width_i  (width_i),
    .height_i (height_i),
    .ready_i  (out_ready_i),
    .valid_o  (out_valid_o),
    .x_o      (out_x_o),
    .y_o      (out_y_o),
    .done_o   (done_o),
    .load_o   (load),
    .nx_o     (nx),
    .ny_o     (ny),
    .nw_o     (nw)
  );

  ttile_mapper #(.COORD_W(COORD_W)) mapper_i (
    .x_i   (nx),
    .y_i   (ny),
    .w_i   (nw),
    .off_o (off_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (load) begin
      off_q <= off_d;
    end
  end

  assign out_offset_o = off_q;

  // R4: a stalled pixel keeps every output field
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_x_o)
      && $stable(out_y_o) && $stable(out_offset_o)));

  // R5: done lasts a single cycle
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: done only follows a handshake and coincides with idle output
  p_done_after_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (!out_valid_o && $past(out_valid_o && out_ready_i)));

  // R7: pixels inside a micro-tile are word aligned
  p_word_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (out_offset_o[1:0] == 2'b00));
endmodule

// File: tb/ttile_addr_gen_tb_top.sv
module ttile_addr_gen_tb_top;
  localparam int CW = 12;
  localparam int OW = 2 * CW + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [CW-1:0] width_i, height_i;
  logic          out_ready_i;
  logic          out_valid_o, done_o;
  logic [CW-1:0] out_x_o, out_y_o;
  logic [OW-1:0] out_offset_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ttile_addr_gen #(.COORD_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .width_i(width_i),
    .height_i(height_i), .out_ready_i(out_ready_i), .out_valid_o(out_valid_o),
    .out_x_o(out_x_o), .out_y_o(out_y_o), .out_offset_o(out_offset_o),
    .done_o(done_o)
  );

  function automatic int ref_off(int x, int y, int w);
    int tpr, tx, ty, col, slot, micro, pix;
    bit rgt, bot;
    tpr = (w + 31) / 32;
    tx  = x / 32;
    ty  = y / 32;
    col = (ty % 2 == 1) ? (tpr - 1 - tx) : tx;
    rgt = (x % 32) >= 16;
    bot = (y % 32) >= 16;
    if (ty % 2 == 0) begin
      if (!rgt) slot = bot ? 0 : 1;
      else      slot = bot ? 3 : 2;
    end else begin
      if (rgt)  slot = bot ? 1 : 0;
      else      slot = bot ? 2 : 3;
    end
    micro = ((y % 16) / 4) * 4 + (x % 16) / 4;
    pix   = (y % 4) * 4 + (x % 4);
    return (ty * tpr + col) * 4096 + slot * 1024 + micro * 64 + pix * 4;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0: always ready, 1: ready 2 of 3 cycles, 2: irregular
  // poke_w > 0 pulses start with that width at pixel 50 (R6)
  task automatic run_window(int w, int h, int mode, int poke_w);
    int ex = 0, ey = 0, n = 0, cyc = 0;
    bit acc_last = 0, fin = 0;
    bit prev_stall = 0;
    int px = 0, py = 0, poff = 0;
    @(negedge clk);
    width_i = CW'(w); height_i = CW'(h); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    width_i = CW'(1); height_i = CW'(1);
    check(out_valid_o && out_x_o == 0 && out_y_o == 0, "R2 first pixel",
          int'(out_x_o), 0);
    while (!fin) begin
      if (acc_last) begin
        check(done_o && !out_valid_o, "R5 done after last", int'(done_o), 1);
        @(negedge clk);
        check(!done_o, "R5 done single cycle", int'(done_o), 0);
        fin = 1;
      end else begin
        if (done_o) check(0, "R5 early done", 1, 0);
        if (prev_stall)
          check(out_valid_o && out_x_o == CW'(px) && out_y_o == CW'(py)
                && out_offset_o == OW'(poff), "R4 stall hold",
                int'(out_offset_o), poff);
        check(out_valid_o && out_x_o == CW'(ex) && out_y_o == CW'(ey),
              "R3 raster coords", int'(out_y_o) * 4096 + int'(out_x_o),
              ey * 4096 + ex);
        check(out_offset_o == OW'(ref_off(ex, ey, w)),
              "R7/R8/R9/R10 offset", int'(out_offset_o), ref_off(ex, ey, w));
        case (mode)
          0: out_ready_i = 1'b1;
          1: out_ready_i = (cyc % 3) != 0;
          default: out_ready_i = ((cyc * 7) % 5) < 3;
        endcase
        start_i = (poke_w > 0 && n == 50);
        if (start_i) width_i = CW'(poke_w);
        cyc++;
        prev_stall = !out_ready_i;
        px = ex; py = ey; poff = ref_off(ex, ey, w);
        if (out_ready_i) begin
          n++;
          if (ex == w - 1 && ey == h - 1) acc_last = 1;
          else if (ex == w - 1) begin ex = 0; ey++; end
          else ex++;
        end
        @(negedge clk);
        start_i = 1'b0;
      end
    end
    out_ready_i = 1'b0;
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(!out_valid_o, "R1 valid low after reset", int'(out_valid_o), 0);
    check(!done_o, "R1 done low after reset", int'(done_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; out_ready_i = 1'b0;
    width_i = '0; height_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_window(1, 1, 0, 0);
    run_window(8, 3, 1, 0);
    run_window(32, 32, 0, 0);
    run_window(45, 37, 2, 0);
    run_window(70, 65, 1, 0);
    run_window(40, 34, 0, 9);   // R6 start during walk
    run_window(17, 66, 2, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule